// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit executes one single-bit instruction per cycle on an 8-bit operand. The caller presents the operand byte, a bit selector, an operation code, and the current carry and zero flags, all qualified by a valid strobe. One clock later the unit returns four things: the resulting byte, a write-back enable that says whether that byte should be stored, and the updated carry and zero flags.

The operations fall into three groups:
- **Byte modifiers.** Set, clear and invert change one bit of the byte. Store copies the carry (or its complement) into one bit.
- **Test.** Test reports the state of one bit through the zero flag.
- **Carry accumulator.** The carry acts as a one-bit accumulator. It can be loaded from a selected bit, or combined with that bit by AND, OR or XOR. Every one of these has a variant that complements the selected bit first.

Operand fetch and addressing belong to the surrounding pipeline. Operations may be issued back to back, one per cycle.

Top module: `bitop_unit`

## Requirements
- R1: While reset (rstN low) is asserted, and on the first cycle after it, resValid, wrEn, dataOut, cOut and zOut are all zero.
- R2: The selected bit is bit (bitNum mod 8), so the mask is 1 shifted left by the low three bits of bitNum. The upper bits of bitNum have no effect.
- R3: Opcode 0 sets, 1 clears and 2 inverts the selected bit. The result appears with wrEn=1, and cOut and zOut equal cIn and zIn.
- R4: Opcode 3 (test) drives zOut=1 when the selected bit is 0 and zOut=0 when it is 1. It returns dataOut equal to dataIn, with wrEn=0 and cOut=cIn.
- R5: Opcode 4 copies the selected bit into cOut. Opcode 5 copies its complement into cOut.
- R6: Opcode 6 writes cIn into the selected bit, and opcode 7 writes the complement of cIn. Both give wrEn=1 and keep cOut=cIn and zOut=zIn.
- R7: Opcodes 8, 10 and 12 set cOut to the selected bit AND, OR and XOR cIn respectively. Opcodes 9, 11 and 13 do the same with the complement of the selected bit.
- R8: Opcodes 4, 5 and 8 to 13 leave the byte unchanged (dataOut=dataIn), give wrEn=0 and keep zOut=zIn.
- R9: Opcodes 14 and 15 have no effect: dataOut=dataIn, wrEn=0, cOut=cIn, zOut=zIn.
- R10: A result appears exactly one cycle after opValid, with resValid=1. A new operation is accepted every cycle. In a cycle that follows no operation, resValid and wrEn are 0 and dataOut, cOut and zOut hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation code (see R3 to R9) |
| bitNum | input | 4 | Bit selector; only the low 3 bits are used |
| dataIn | input | 8 | Operand byte |
| cIn | input | 1 | Current carry flag |
| zIn | input | 1 | Current zero flag |
| resValid | output | 1 | Result valid |
| dataOut | output | 8 | Resulting byte |
| wrEn | output | 1 | Write-back requested |
| cOut | output | 1 | Updated carry flag |
| zOut | output | 1 | Updated zero flag |

## Verification
Two things coincide in every cycle of a back-to-back stream: the result of one operation leaves the output registers while the next operation is captured. The vector table is therefore issued on consecutive cycles, mixing writing and non-writing operations and alternating flag values. Each registered output is compared with its own vector one cycle after issue. A stale carry, a stale zero flag or a lingering write enable from the previous operation would then show up as a mismatch.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int OP_W = 4;

  typedef enum logic [3:0] {
    FN_NONE,
    FN_SET,
    FN_CLR,
    FN_INV,
    FN_TEST,
    FN_LOAD,
    FN_STORE,
    FN_AND,
    FN_OR,
    FN_XOR
  } fnKind_t;

  typedef struct packed {
    fnKind_t fn;
    logic    wrBack;
    logic    invBit;
  } bitStrobe_t;

endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output bitStrobe_t      strobe
);

  always_comb begin
    strobe.fn     = FN_NONE;
    strobe.wrBack = 1'b0;
    strobe.invBit = 1'b0;
    unique case (opCode)
      4'd0:  begin strobe.fn = FN_SET;   strobe.wrBack = 1'b1; end
      4'd1:  begin strobe.fn = FN_CLR;   strobe.wrBack = 1'b1; end
      4'd2:  begin strobe.fn = FN_INV;   strobe.wrBack = 1'b1; end
      4'd3:  begin strobe.fn = FN_TEST;  end
      4'd4:  begin strobe.fn = FN_LOAD;  end
      4'd5:  begin strobe.fn = FN_LOAD;  strobe.invBit = 1'b1; end
      4'd6:  begin strobe.fn = FN_STORE; strobe.wrBack = 1'b1; end
      4'd7:  begin strobe.fn = FN_STORE; strobe.wrBack = 1'b1; strobe.invBit = 1'b1; end
      4'd8:  begin strobe.fn = FN_AND;   end
      4'd9:  begin strobe.fn = FN_AND;   strobe.invBit = 1'b1; end
      4'd10: begin strobe.fn = FN_OR;    end
      4'd11: begin strobe.fn = FN_OR;    strobe.invBit = 1'b1; end
      4'd12: begin strobe.fn = FN_XOR;   end
      4'd13: begin strobe.fn = FN_XOR;   strobe.invBit = 1'b1; end
      default: begin strobe.fn = FN_NONE; end
    endcase
  end

endmodule

// File: rtl/bitop_dp.sv
module bitop_dp
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  bitStrobe_t        strobe,
  input  logic [SEL_W-1:0]  bitNum,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cIn,
  input  logic              zIn,
  output logic              resValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              wrEn,
  output logic              cOut,
  output logic              zOut
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] bitMask;
  logic              selBit;
  logic              effBit;
  logic [DATA_W-1:0] nextByte;
  logic              nextC;
  logic              nextZ;

  assign bitIdx  = bitNum[IDX_W-1:0];
  assign bitMask = {{(DATA_W-1){1'b0}}, 1'b1} << bitIdx;
  assign selBit  = |(dataIn & bitMask);
  assign effBit  = selBit ^ strobe.invBit;

  always_comb begin
    nextByte = dataIn;
    nextC    = cIn;
    nextZ    = zIn;
    case (strobe.fn)
      FN_SET:   nextByte = dataIn | bitMask;
      FN_CLR:   nextByte = dataIn & ~bitMask;
      FN_INV:   nextByte = dataIn ^ bitMask;
      FN_TEST:  nextZ    = ~selBit;
      FN_LOAD:  nextC    = effBit;
      FN_STORE: nextByte = (cIn ^ strobe.invBit) ? (dataIn | bitMask)
                                                 : (dataIn & ~bitMask);
      FN_AND:   nextC    = effBit & cIn;
      FN_OR:    nextC    = effBit | cIn;
      FN_XOR:   nextC    = effBit ^ cIn;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      wrEn     <= 1'b0;
      dataOut  <= '0;
      cOut     <= 1'b0;
      zOut     <= 1'b0;
    end else begin
      resValid <= opValid;
      wrEn     <= opValid & strobe.wrBack;
      if (opValid) begin
        dataOut <= nextByte;
        cOut    <= nextC;
        zOut    <= nextZ;
      end
    end
  end

  // R10
  wr_without_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> resValid);

  // R8
  byte_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !wrEn) |-> (dataOut == $past(dataIn)));

  // R3
  single_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($countones(dataOut ^ $past(dataIn)) <= 1));

  // R6
  flags_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && wrEn) |-> (cOut == $past(cIn) && zOut == $past(zIn)));

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && $past(rstN)) |=> ($stable(dataOut) && $stable(cOut) && $stable(zOut)));

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [SEL_W-1:0]  bitNum,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cIn,
  input  logic              zIn,
  output logic              resValid,
  output logic [DATA_W-1:0] dataOut,
  output logic              wrEn,
  output logic              cOut,
  output logic              zOut
);

  bitStrobe_t strobe;

  bitop_ctrl u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  bitop_dp #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .strobe   (strobe),
    .bitNum   (bitNum),
    .dataIn   (dataIn),
    .cIn      (cIn),
    .zIn      (zIn),
    .resValid (resValid),
    .dataOut  (dataOut),
    .wrEn     (wrEn),
    .cOut     (cOut),
    .zOut     (zOut)
  );

endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;

  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [3:0] opCode;
  logic [3:0] bitNum;
  logic [7:0] dataIn;
  logic       cIn;
  logic       zIn;
  logic       resValid;
  logic [7:0] dataOut;
  logic       wrEn;
  logic       cOut;
  logic       zOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitop_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .bitNum(bitNum), .dataIn(dataIn), .cIn(cIn), .zIn(zIn),
    .resValid(resValid), .dataOut(dataOut), .wrEn(wrEn),
    .cOut(cOut), .zOut(zOut)
  );

  // {op, bit, data, c, z, expData, expWr, expC, expZ}
  localparam int NV = 22;
  localparam logic [28:0] VECS [0:NV-1] = '{
    {4'd0,  4'd3,  8'h00, 1'b0, 1'b0, 8'h08, 1'b1, 1'b0, 1'b0},
    {4'd0,  4'd7,  8'h7F, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1},
    {4'd1,  4'd0,  8'hFF, 1'b0, 1'b1, 8'hFE, 1'b1, 1'b0, 1'b1},
    {4'd2,  4'd5,  8'h20, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0},
    {4'd2,  4'd5,  8'h00, 1'b0, 1'b0, 8'h20, 1'b1, 1'b0, 1'b0},
    {4'd3,  4'd2,  8'hFB, 1'b1, 1'b0, 8'hFB, 1'b0, 1'b1, 1'b1},
    {4'd3,  4'd2,  8'h04, 1'b0, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0},
    {4'd4,  4'd6,  8'h40, 1'b0, 1'b1, 8'h40, 1'b0, 1'b1, 1'b1},
    {4'd5,  4'd6,  8'h40, 1'b1, 1'b0, 8'h40, 1'b0, 1'b0, 1'b0},
    {4'd6,  4'd1,  8'h00, 1'b1, 1'b1, 8'h02, 1'b1, 1'b1, 1'b1},
    {4'd7,  4'd1,  8'hFF, 1'b1, 1'b0, 8'hFD, 1'b1, 1'b1, 1'b0},
    {4'd6,  4'd4,  8'hFF, 1'b0, 1'b0, 8'hEF, 1'b1, 1'b0, 1'b0},
    {4'd8,  4'd0,  8'h01, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0},
    {4'd8,  4'd0,  8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1},
    {4'd9,  4'd0,  8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    {4'd10, 4'd7,  8'h80, 1'b0, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0},
    {4'd11, 4'd7,  8'h80, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0, 1'b1},
    {4'd12, 4'd3,  8'h08, 1'b1, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0},
    {4'd13, 4'd3,  8'h08, 1'b1, 1'b1, 8'h08, 1'b0, 1'b1, 1'b1},
    {4'd0,  4'd11, 8'h00, 1'b0, 1'b0, 8'h08, 1'b1, 1'b0, 1'b0},
    {4'd14, 4'd2,  8'h55, 1'b1, 1'b1, 8'h55, 1'b0, 1'b1, 1'b1},
    {4'd15, 4'd0,  8'hAA, 1'b0, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b0}
  };

  function automatic string reqOf(input int idx, input logic [3:0] op);
    if (idx == 19) return "R2";
    case (op)
      4'd0, 4'd1, 4'd2: return "R3";
      4'd3:             return "R4";
      4'd4, 4'd5:       return "R5";
      4'd6, 4'd7:       return "R6";
      4'd14, 4'd15:     return "R9";
      default:          return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; opValid = 1'b0; opCode = '0; bitNum = '0;
    dataIn = '0; cIn = 1'b0; zIn = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "resValid", {7'd0, resValid}, 8'd0);
    check("R1", "wrEn", {7'd0, wrEn}, 8'd0);
    check("R1", "dataOut", dataOut, 8'd0);
    check("R1", "flags", {6'd0, cOut, zOut}, 8'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1", "first cycle resValid", {7'd0, resValid}, 8'd0);
    check("R1", "first cycle flags", {6'd0, cOut, zOut}, 8'd0);

    // back-to-back vector stream
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opValid = 1'b1;
      {opCode, bitNum, dataIn, cIn, zIn} = VECS[i][28:11];
      @(posedge clk); #1;
      check(reqOf(i, VECS[i][28:25]), "dataOut", dataOut, VECS[i][10:3]);
      check(reqOf(i, VECS[i][28:25]), "wrEn", {7'd0, wrEn}, {7'd0, VECS[i][2]});
      check(reqOf(i, VECS[i][28:25]), "cOut", {7'd0, cOut}, {7'd0, VECS[i][1]});
      check(reqOf(i, VECS[i][28:25]), "zOut", {7'd0, zOut}, {7'd0, VECS[i][0]});
      check("R10", "resValid", {7'd0, resValid}, 8'd1);
    end

    // R10 idle cycle: garbage inputs with opValid low
    @(negedge clk);
    opValid = 1'b0; opCode = 4'd0; bitNum = 4'd1; dataIn = 8'h00; cIn = 1'b1; zIn = 1'b0;
    @(posedge clk); #1;
    check("R10", "idle resValid", {7'd0, resValid}, 8'd0);
    check("R10", "idle wrEn", {7'd0, wrEn}, 8'd0);
    check("R10", "idle dataOut hold", dataOut, 8'hAA);
    check("R10", "idle flags hold", {6'd0, cOut, zOut}, 8'd0);

    // R8 load complement of bit 0 with upper bitNum bits set (R2)
    @(negedge clk);
    opValid = 1'b1; opCode = 4'd5; bitNum = 4'd8; dataIn = 8'hFE; cIn = 1'b0; zIn = 1'b1;
    @(posedge clk); #1;
    check("R8", "load keeps byte", dataOut, 8'hFE);
    check("R8", "load no write", {7'd0, wrEn}, 8'd0);
    check("R8", "load keeps Z", {7'd0, zOut}, 8'd1);
    check("R2", "bit 8 selects bit 0", {7'd0, cOut}, 8'd1);

    @(negedge clk);
    opValid = 1'b0;
    @(posedge clk); #1;
    check("R10", "valid drops", {7'd0, resValid}, 8'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule